// File: doc/BRIEF.md
# Write-Locked Trim Register Map

This block is the register file behind a trim-resistor controller. Thirty-two byte addresses sit behind a byte-wide read and write port. The map holds a device address byte, a configuration byte with two high-impedance controls, two 8-bit position codes, a two-byte volatile password entry, a two-byte stored password and sixteen user bytes. The position codes, the high-impedance enables and the device address byte drive the rest of the chip directly. A per-page dirty vector tells a commit engine which two-byte pages of stored content changed since it last cleared them.

Write protection is a live comparison. While the password entry equals the stored password, every writable location takes writes. While they differ, only the entry takes writes, and every readable location can still be read. Both values reset to FFFFh, so the map comes up writable. The password entry can never be read back.

Requests pass through a three-state access sequencer. In `ST_IDLE` nothing is pending. A sampled `wr_en` moves the sequencer to `ST_WRITE` from any state. Otherwise a sampled `rd_en` moves it to `ST_READ`. Otherwise it goes back to `ST_IDLE`. The sequencer commits the write during `ST_WRITE` and loads the read data during `ST_READ`. The request address and data are captured together with the state.

Top module: `trim_regmap`

## Requirements
- R1: After reset, reads return A0h at 00h, 00h at 01h, 7Fh at 02h and 03h, FFh at 06h and 07h and FFh at 10h–1Fh, and the dirty vector is all zero.
- R2: A read sampled on a clock edge gives `rd_valid` high for one cycle after the second edge, with `rdata` holding the byte at that address. A read sampled on the edge after a write sees the written value.
- R3: When `wr_en` and `rd_en` are sampled high together, the write is performed and the read is dropped: no `rd_valid` follows it.
- R4: Configuration byte 01h: bit 0 high makes `hiz0` high and bit 1 high makes `hiz1` high. Writing 0 to a bit clears that output. Bits 7:2 are not stored and read as 0.
- R5: `pos0` and `pos1` always equal the bytes at 02h and 03h. Code 00h is minimum resistance and FFh is maximum resistance.
- R6: The password entry is at 04h (high byte) and 05h (low byte). It is always writable, always reads FFh, and a write to it never sets a dirty bit.
- R7: Addresses 08h–0Fh read FFh. Writes to them change nothing and set no dirty bit.
- R8: The map is unlocked while the entry {04h,05h} equals the setting {06h,07h}. The setting is at 06h (high byte) and 07h (low byte). Writing the matching entry unlocks the map from the next request on.
- R9: While locked, writes to every address except 04h and 05h are dropped silently, with no change to any readable byte, output or dirty bit. Reads still work.
- R10: An accepted write to a stored address (00h–03h, 06h–07h, 10h–1Fh) sets dirty bit addr[4:1]. A `dirty_clr` bit clears its page flag on the edge where it is sampled, and a set on the same edge wins.
- R11: `dev_addr_byte` always equals the full 8-bit byte at 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write request, sampled on the clock edge |
| rd_en | input | 1 | Read request, sampled on the clock edge |
| addr | input | 5 | Byte address of the request |
| wdata | input | 8 | Write data |
| dirty_clr | input | 16 | Per-page clear of the dirty flags |
| rdata | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | One-cycle read data strobe |
| dev_addr_byte | output | 8 | Stored device address byte |
| pos0 | output | 8 | Position code for resistor 0 |
| pos1 | output | 8 | Position code for resistor 1 |
| hiz0 | output | 1 | High-impedance enable for resistor 0 |
| hiz1 | output | 1 | High-impedance enable for resistor 1 |
| dirty | output | 16 | Per-page changed flags |

## Verification
A corrupted stored byte shows up two cycles after it is written. It appears either as a wrong value on `pos0`, `pos1`, `hiz0`, `hiz1` or `dev_addr_byte`, or as a wrong byte on the next readback of that address. A wrong lock decision has two visible effects. Either a blocked write leaks through to a position output and its dirty bit, or an accepted write fails to appear on the readback. The bench therefore checks the lock by writing a position register and observing both. A sequencer in the wrong state shows up at once as a missing or extra `rd_valid`, and the scoreboard flags a strobe that has no queued expectation.

// File: rtl/trim_regmap_pkg.sv
package trim_regmap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } acc_state_e;

    localparam int unsigned LOC_DEV    = 0;
    localparam int unsigned LOC_CFG    = 1;
    localparam int unsigned LOC_POS0   = 2;
    localparam int unsigned LOC_POS1   = 3;
    localparam int unsigned LOC_KEY_HI = 4;
    localparam int unsigned LOC_KEY_LO = 5;
    localparam int unsigned LOC_SET_HI = 6;
    localparam int unsigned LOC_SET_LO = 7;
    localparam int unsigned LOC_GAP    = 8;

    localparam logic [7:0] RST_DEV  = 8'hA0;
    localparam logic [7:0] RST_POS  = 8'h7F;
    localparam logic [7:0] RST_FILL = 8'hFF;

endpackage

// File: rtl/trim_regmap_seq.sv
module trim_regmap_seq
    import trim_regmap_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              wr_go,
    output logic              rd_go
);

    acc_state_e state_q;
    acc_state_e state_d;

    // next state: write has priority over read
    always_comb begin
        if (wr_en) begin
            state_d = ST_WRITE;
        end else if (rd_en) begin
            state_d = ST_READ;
        end else begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_addr <= '0;
            cmd_data <= '0;
        end else if (wr_en || rd_en) begin
            cmd_addr <= addr;
            cmd_data <= wdata;
        end
    end

    always_comb begin
        wr_go = 1'b0;
        rd_go = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin end
            ST_WRITE: wr_go = 1'b1;
            ST_READ:  rd_go = 1'b1;
            default:  begin end
        endcase
    end

endmodule

// File: rtl/trim_regmap_guard.sv
module trim_regmap_guard
    import trim_regmap_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned KEY_W  = 2 * DATA_W
) (
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [KEY_W-1:0]  key_entry,
    input  logic [KEY_W-1:0]  key_setting,
    output logic              unlocked,
    output logic              store_we,
    output logic              entry_we
);

    localparam int unsigned USER_BASE = 2 ** (ADDR_W - 1);

    logic is_entry;
    logic is_stored;

    always_comb begin
        is_entry  = (cmd_addr == ADDR_W'(LOC_KEY_HI)) ||
                    (cmd_addr == ADDR_W'(LOC_KEY_LO));
        is_stored = (cmd_addr <= ADDR_W'(LOC_POS1)) ||
                    (cmd_addr == ADDR_W'(LOC_SET_HI)) ||
                    (cmd_addr == ADDR_W'(LOC_SET_LO)) ||
                    (cmd_addr >= ADDR_W'(USER_BASE));
    end

    assign unlocked = (key_entry == key_setting);
    assign entry_we = wr_go && is_entry;
    assign store_we = wr_go && unlocked && is_stored;

endmodule

// File: rtl/trim_regmap_store.sv
module trim_regmap_store
    import trim_regmap_pkg::*;
#(
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned PAGE_BYTES = 2,
    parameter int unsigned NUM_PAGES  = (2 ** ADDR_W) / PAGE_BYTES,
    parameter int unsigned KEY_W      = 2 * DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 store_we,
    input  logic                 entry_we,
    input  logic                 rd_go,
    input  logic                 unlocked,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [DATA_W-1:0]    cmd_data,
    input  logic [NUM_PAGES-1:0] dirty_clr,
    output logic [KEY_W-1:0]     key_entry,
    output logic [KEY_W-1:0]     key_setting,
    output logic [DATA_W-1:0]    dev_byte,
    output logic [DATA_W-1:0]    pos0,
    output logic [DATA_W-1:0]    pos1,
    output logic [1:0]           hiz,
    output logic [NUM_PAGES-1:0] dirty,
    output logic [DATA_W-1:0]    rdata,
    output logic                 rd_valid
);

    localparam int unsigned USER_BASE  = 2 ** (ADDR_W - 1);
    localparam int unsigned USER_BYTES = (2 ** ADDR_W) - USER_BASE;
    localparam int unsigned UIDX_W     = ADDR_W - 1;
    localparam int unsigned PAGE_LSB   = $clog2(PAGE_BYTES);

    logic [DATA_W-1:0] dev_q;
    logic [1:0]        cfg_q;
    logic [DATA_W-1:0] pos_q [2];
    logic [DATA_W-1:0] key_q [2];
    logic [DATA_W-1:0] set_q [2];
    logic [DATA_W-1:0] user_q [USER_BYTES];
    logic [NUM_PAGES-1:0] dirty_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rd_valid_q;
    logic [DATA_W-1:0] rd_mux;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_q <= DATA_W'(RST_DEV);
            cfg_q <= 2'b00;
        end else if (store_we) begin
            if (cmd_addr == ADDR_W'(LOC_DEV)) dev_q <= cmd_data;
            if (cmd_addr == ADDR_W'(LOC_CFG)) cfg_q <= cmd_data[1:0];
        end
    end

    // two-byte groups: position pair, key entry, key setting
    for (genvar g = 0; g < 2; g++) begin : g_pair
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pos_q[g] <= DATA_W'(RST_POS);
            end else if (store_we && cmd_addr == ADDR_W'(LOC_POS0 + g)) begin
                pos_q[g] <= cmd_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                key_q[g] <= DATA_W'(RST_FILL);
            end else if (entry_we && cmd_addr == ADDR_W'(LOC_KEY_HI + g)) begin
                key_q[g] <= cmd_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                set_q[g] <= DATA_W'(RST_FILL);
            end else if (store_we && cmd_addr == ADDR_W'(LOC_SET_HI + g)) begin
                set_q[g] <= cmd_data;
            end
        end
    end

    for (genvar u = 0; u < USER_BYTES; u++) begin : g_user
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                user_q[u] <= DATA_W'(RST_FILL);
            end else if (store_we && cmd_addr == ADDR_W'(USER_BASE + u)) begin
                user_q[u] <= cmd_data;
            end
        end
    end

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_dirty
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dirty_q[p] <= 1'b0;
            end else if (store_we &&
                         cmd_addr[ADDR_W-1:PAGE_LSB] == (ADDR_W-PAGE_LSB)'(p)) begin
                dirty_q[p] <= 1'b1;
            end else if (dirty_clr[p]) begin
                dirty_q[p] <= 1'b0;
            end
        end
    end

    always_comb begin
        if (cmd_addr >= ADDR_W'(USER_BASE)) begin
            rd_mux = user_q[cmd_addr[UIDX_W-1:0]];
        end else if (cmd_addr == ADDR_W'(LOC_DEV)) begin
            rd_mux = dev_q;
        end else if (cmd_addr == ADDR_W'(LOC_CFG)) begin
            rd_mux = {{(DATA_W-2){1'b0}}, cfg_q};
        end else if (cmd_addr == ADDR_W'(LOC_POS0)) begin
            rd_mux = pos_q[0];
        end else if (cmd_addr == ADDR_W'(LOC_POS1)) begin
            rd_mux = pos_q[1];
        end else if (cmd_addr == ADDR_W'(LOC_SET_HI)) begin
            rd_mux = set_q[0];
        end else if (cmd_addr == ADDR_W'(LOC_SET_LO)) begin
            rd_mux = set_q[1];
        end else begin
            rd_mux = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q    <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_go;
            if (rd_go) rdata_q <= rd_mux;
        end
    end

    assign key_entry   = {key_q[0], key_q[1]};
    assign key_setting = {set_q[0], set_q[1]};
    assign dev_byte    = dev_q;
    assign pos0        = pos_q[0];
    assign pos1        = pos_q[1];
    assign hiz         = cfg_q;
    assign dirty       = dirty_q;
    assign rdata       = rdata_q;
    assign rd_valid    = rd_valid_q;

    // R7: gap addresses read as all ones
    p_gap_reads_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && cmd_addr >= ADDR_W'(LOC_GAP) && cmd_addr < ADDR_W'(USER_BASE))
        |=> (rdata_q == '1));

    // R10: accepted user write marks its page
    p_user_dirty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (store_we && unlocked && cmd_addr >= ADDR_W'(USER_BASE))
        |=> dirty_q[$past(cmd_addr[ADDR_W-1:PAGE_LSB])]);

    // R6 / R10: entry writes leave the dirty vector untouched
    p_entry_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_we && dirty_clr == '0) |=> $stable(dirty_q));

endmodule

// File: rtl/trim_regmap.sv
module trim_regmap
    import trim_regmap_pkg::*;
#(
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned PAGE_BYTES = 2,
    parameter int unsigned NUM_PAGES  = (2 ** ADDR_W) / PAGE_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_PAGES-1:0] dirty_clr,
    output logic [DATA_W-1:0]    rdata,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    dev_addr_byte,
    output logic [DATA_W-1:0]    pos0,
    output logic [DATA_W-1:0]    pos1,
    output logic                 hiz0,
    output logic                 hiz1,
    output logic [NUM_PAGES-1:0] dirty
);

    localparam int unsigned KEY_W = 2 * DATA_W;

    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              wr_go;
    logic              rd_go;
    logic              unlocked;
    logic              store_we;
    logic              entry_we;
    logic [KEY_W-1:0]  key_entry;
    logic [KEY_W-1:0]  key_setting;
    logic [1:0]        hiz;

    trim_regmap_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data),
        .wr_go    (wr_go),
        .rd_go    (rd_go)
    );

    trim_regmap_guard #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .KEY_W  (KEY_W)
    ) guard_i (
        .wr_go       (wr_go),
        .cmd_addr    (cmd_addr),
        .key_entry   (key_entry),
        .key_setting (key_setting),
        .unlocked    (unlocked),
        .store_we    (store_we),
        .entry_we    (entry_we)
    );

    trim_regmap_store #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES),
        .NUM_PAGES  (NUM_PAGES),
        .KEY_W      (KEY_W)
    ) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .store_we    (store_we),
        .entry_we    (entry_we),
        .rd_go       (rd_go),
        .unlocked    (unlocked),
        .cmd_addr    (cmd_addr),
        .cmd_data    (cmd_data),
        .dirty_clr   (dirty_clr),
        .key_entry   (key_entry),
        .key_setting (key_setting),
        .dev_byte    (dev_addr_byte),
        .pos0        (pos0),
        .pos1        (pos1),
        .hiz         (hiz),
        .dirty       (dirty),
        .rdata       (rdata),
        .rd_valid    (rd_valid)
    );

    assign hiz0 = hiz[0];
    assign hiz1 = hiz[1];

    // R2: a lone read request yields a strobe two edges later
    p_read_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> ##1 rd_valid);

    // R3: a sampled write suppresses any strobe in its slot
    p_write_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ##1 !rd_valid);

    // R9: locked map keeps position 0 unchanged under a write to it
    p_locked_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !unlocked && cmd_addr == ADDR_W'(LOC_POS0)) |=> $stable(pos0));

endmodule

// File: tb/trim_regmap_tb_top.sv
module trim_regmap_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [15:0] dirty_clr = '0;
    logic [7:0]  rdata;
    logic        rd_valid;
    logic [7:0]  dev_addr_byte;
    logic [7:0]  pos0;
    logic [7:0]  pos1;
    logic        hiz0;
    logic        hiz1;
    logic [15:0] dirty;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    trim_regmap dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .addr          (addr),
        .wdata         (wdata),
        .dirty_clr     (dirty_clr),
        .rdata         (rdata),
        .rd_valid      (rd_valid),
        .dev_addr_byte (dev_addr_byte),
        .pos0          (pos0),
        .pos1          (pos1),
        .hiz0          (hiz0),
        .hiz1          (hiz1),
        .dirty         (dirty)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #2;
        rd_en = 1'b1; addr = a;
        @(posedge clk); #2;
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_errors++;
                $display("FAIL R3: unexpected read strobe, got %0h expected none", rdata);
            end else begin
                check(tag_q.pop_front(), {24'h0, rdata}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1 / R11 reset state
        check("R1 pos0", pos0, 32'h7F);
        check("R1 pos1", pos1, 32'h7F);
        check("R1 hiz", {hiz1, hiz0}, 32'h0);
        check("R11 dev byte", dev_addr_byte, 32'hA0);
        check("R1 dirty", dirty, 32'h0);
        do_read(5'h00, 8'hA0, "R1 read 00");
        do_read(5'h01, 8'h00, "R1 read 01");
        do_read(5'h02, 8'h7F, "R1 read 02");
        do_read(5'h03, 8'h7F, "R1 read 03");
        do_read(5'h06, 8'hFF, "R1 read 06");
        do_read(5'h07, 8'hFF, "R1 read 07");
        do_read(5'h10, 8'hFF, "R1 read 10");
        do_read(5'h1F, 8'hFF, "R1 read 1F");
        do_read(5'h04, 8'hFF, "R6 entry read");
        do_read(5'h09, 8'hFF, "R7 gap read");

        // R5 position codes, R2 read after write
        do_write(5'h02, 8'h00);
        do_read(5'h02, 8'h00, "R2 readback 02");
        do_write(5'h03, 8'hFF);
        settle();
        check("R5 pos0 min", pos0, 32'h00);
        check("R5 pos1 max", pos1, 32'hFF);
        check("R10 dirty page1", dirty, 32'h0002);

        // R4 configuration
        do_write(5'h01, 8'hFF);
        settle();
        check("R4 hiz both", {hiz1, hiz0}, 32'h3);
        do_read(5'h01, 8'h03, "R4 cfg upper bits zero");
        do_write(5'h01, 8'h02);
        settle();
        check("R4 hiz0 cleared", {hiz1, hiz0}, 32'h2);

        // R11 device byte
        do_write(5'h00, 8'h5B);
        settle();
        check("R11 dev byte write", dev_addr_byte, 32'h5B);
        check("R10 dirty page0", dirty, 32'h0003);

        // R7 gap writes ignored
        do_write(5'h0A, 8'h12);
        do_read(5'h0A, 8'hFF, "R7 gap after write");
        settle();
        check("R7 gap no dirty", dirty, 32'h0003);

        // R6 entry write then restore; reads FF, no dirty
        do_write(5'h04, 8'hFF);
        do_read(5'h04, 8'hFF, "R6 entry still FF");
        settle();
        check("R6 entry no dirty", dirty, 32'h0003);

        // R9 lock by changing setting high byte
        do_write(5'h06, 8'hAB);
        settle();
        check("R10 dirty page3", dirty, 32'h000B);
        do_write(5'h02, 8'h66);
        settle();
        check("R9 blocked pos0", pos0, 32'h00);
        check("R9 blocked dirty", dirty, 32'h000B);
        do_read(5'h02, 8'h00, "R9 blocked readback");
        do_read(5'h06, 8'hAB, "R9 read while locked");
        do_write(5'h10, 8'h44);
        do_read(5'h10, 8'hFF, "R9 blocked user byte");

        // R8 unlock with matching entry
        do_write(5'h04, 8'hAB);
        do_write(5'h05, 8'hFF);
        do_write(5'h02, 8'h55);
        settle();
        check("R8 unlocked pos0", pos0, 32'h55);
        do_write(5'h07, 8'hCD);
        do_write(5'h03, 8'h11);
        settle();
        check("R9 locked pos1", pos1, 32'hFF);
        do_write(5'h05, 8'hCD);
        do_write(5'h10, 8'h77);
        do_read(5'h10, 8'h77, "R8 user write unlocked");
        do_write(5'h1F, 8'h01);
        do_read(5'h1F, 8'h01, "R8 last user byte");
        do_read(5'h07, 8'hCD, "R8 setting low");
        settle();
        check("R10 dirty user pages", dirty, 32'h810B);

        // R10 clear, then set wins over clear
        @(posedge clk); #2;
        dirty_clr = 16'hFFFF;
        @(posedge clk); #2;
        dirty_clr = 16'h0000;
        settle();
        check("R10 dirty cleared", dirty, 32'h0000);
        @(posedge clk); #2;
        wr_en = 1'b1; addr = 5'h12; wdata = 8'h44;
        @(posedge clk); #2;
        wr_en = 1'b0; dirty_clr = 16'hFFFF;
        @(posedge clk); #2;
        dirty_clr = 16'h0000;
        settle();
        check("R10 set wins", dirty, 32'h0200);

        // R3 write and read together
        @(posedge clk); #2;
        wr_en = 1'b1; rd_en = 1'b1; addr = 5'h11; wdata = 8'h33;
        @(posedge clk); #2;
        wr_en = 1'b0; rd_en = 1'b0;
        settle();
        do_read(5'h11, 8'h33, "R3 write performed");
        settle();
        check("R3 dirty page8", dirty, 32'h0300);
        check("R3 queue drained", exp_q.size(), 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule